// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Serialisation

This block is a shared on-chip scratchpad made of a row of independent single-port word banks. A group of lanes presents one access per lane in the same cycle: every lane carries a word address, an active bit and write data, and the whole group is either a read or a write. The block finds each lane's bank from the low address bits and works out which lanes collide in a bank. It then serves the group over several passes, and the number of passes equals the request count of the busiest bank.

A group is offered with `req_valid` while `req_ready` is high. `req_ready` stays low until every active lane has been served. When the last read has landed in its lane's result register, the block raises `rsp_done` for one cycle. The per-lane results then stay in place until the next group is taken. Address patterns that spread across the banks finish in one pass. Patterns that pile onto one bank take up to one pass per lane.

Top module: `bank_scratchpad`

## Requirements
- R1: A lane's word address selects bank = address bits [4:0] (address mod 32) and row = address bits [10:5]. A word written at an address is returned by a later read of that same address.
- R2: Each bank serves at most one lane per cycle. Among the still-pending lanes that map to a bank, the lowest-numbered lane is served first. When a write group has several active lanes on the same address, the highest-numbered of those lanes therefore leaves its data in memory.
- R3: Let N be the largest number of active lanes that map to any one bank, with N taken as 1 when no lane is active. If the group is accepted at clock edge E, then `rsp_done` is high in the cycle that follows edge E+N+1.
- R4: When lane i uses address 32*i + c for a fixed c, all lanes fall in one bank and the group takes 32 passes, so `rsp_done` comes 34 cycles after acceptance.
- R5: When lane i uses address 33*i, each lane falls in its own bank and the group takes one pass, so `rsp_done` comes 3 cycles after acceptance.
- R6: A lane whose active bit is clear takes no bank slot, adds nothing to the conflict count, does not change memory, and has a read result of zero.
- R7: For a read group, lane i's result (bits [32*i+31:32*i] of `rsp_rdata`) is the word at its address. All lanes of a write group read back zero. The results are cleared when a group is accepted and then stay unchanged from `rsp_done` until the next group is accepted.
- R8: `req_ready` is low from the acceptance edge until the `rsp_done` cycle. While `req_ready` is low, `req_valid` and all request fields are ignored.
- R9: `rsp_done` is high for exactly one cycle per accepted group, and `req_ready` is high in that cycle.
- R10: After synchronous reset, `req_ready` is 1, `rsp_done` is 0 and every lane result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A group is offered |
| req_ready | output | 1 | The block is idle and can take a group |
| req_we | input | 1 | 1 = write group, 0 = read group |
| req_mask | input | 32 | Per-lane active bits |
| req_addr | input | 352 | Per-lane 11-bit word addresses; lane i is at [11*i+10:11*i] |
| req_wdata | input | 1024 | Per-lane write words; lane i is at [32*i+31:32*i] |
| rsp_rdata | output | 1024 | Per-lane read results; lane i is at [32*i+31:32*i] |
| rsp_done | output | 1 | One-cycle pulse when the group is complete |

## Verification
The embedded properties check several rules on every cycle:
- Only pending lanes are granted.
- No lower pending lane shares a granted lane's bank.
- A pending lane with no lower rival is always granted.
- Every pass retires at least one lane.
- Inactive lanes read zero.
- The results hold while the block is idle.
- Readiness is withheld while lanes are pending.
- The done pulse lasts one cycle.

Only the bench's scenarios can show the end-to-end effects:
- Exact pass counts for the stride-32, stride-33, masked and random patterns.
- The data a read actually returns.
- Last-lane-wins on duplicate write addresses.
- That a request offered while busy leaves memory untouched.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } spm_state_e;

endpackage

// File: rtl/spm_bank.sv
module spm_bank #(
  parameter int ROWS = 64,
  parameter int DW   = 32,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [ROWS];

  // single port, registered read, read-before-write
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[row] <= wdata;
      end
      rdata <= mem[row];
    end
  end

endmodule

// File: rtl/spm_arbiter.sv
module spm_arbiter #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]         pending,
  input  logic [LANES-1:0][BW-1:0] lane_bank,
  output logic [LANES-1:0]         grant,
  output logic [BANKS-1:0]         bank_hit,
  output logic [BANKS-1:0][LW-1:0] bank_lane
);

  // per bank: pick the lowest-numbered pending lane that maps here
  for (genvar b = 0; b < BANKS; b++) begin : g_pick
    always_comb begin
      bank_hit[b]  = 1'b0;
      bank_lane[b] = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (pending[l] && (lane_bank[l] == BW'(b))) begin
          bank_hit[b]  = 1'b1;
          bank_lane[b] = LW'(l);
        end
      end
    end
  end

  // per lane: granted when its bank picked it
  for (genvar l = 0; l < LANES; l++) begin : g_grant
    assign grant[l] = bank_hit[lane_bank[l]] && (bank_lane[lane_bank[l]] == LW'(l));
  end

endmodule

// File: rtl/spm_return.sv
module spm_return #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS)
) (
  input  logic [BANKS-1:0][DW-1:0] bank_dout,
  input  logic [LANES-1:0][BW-1:0] lane_bank,
  output logic [LANES-1:0][DW-1:0] lane_dout
);

  for (genvar l = 0; l < LANES; l++) begin : g_ret
    assign lane_dout[l] = bank_dout[lane_bank[l]];
  end

endmodule

// File: rtl/bank_scratchpad.sv
module bank_scratchpad
  import spm_pkg::*;
#(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int ROWS  = 64,
  parameter int DW    = 32,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = $clog2(ROWS),
  localparam int AW   = BW + RW,
  localparam int LW   = $clog2(LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [LANES-1:0]      req_mask,
  input  logic [LANES*AW-1:0]   req_addr,
  input  logic [LANES*DW-1:0]   req_wdata,
  output logic [LANES*DW-1:0]   rsp_rdata,
  output logic                  rsp_done
);

  spm_state_e                  state;
  logic [LANES-1:0]            pending;
  logic [LANES-1:0]            mask_q;
  logic                        we_q;
  logic [LANES-1:0][AW-1:0]    addr_q;
  logic [LANES-1:0][DW-1:0]    wd_q;
  logic [LANES-1:0]            gnt_q;
  logic [LANES-1:0][DW-1:0]    rd_q;

  logic [LANES-1:0][BW-1:0]    lane_bank;
  logic [LANES-1:0][RW-1:0]    lane_row;
  logic [LANES-1:0]            grant;
  logic [BANKS-1:0]            bank_hit;
  logic [BANKS-1:0][LW-1:0]    bank_lane;
  logic [BANKS-1:0][DW-1:0]    bank_dout;
  logic [LANES-1:0][DW-1:0]    lane_dout;
  logic [LANES-1:0]            left_after;

  // address split: low bits pick the bank, high bits the row
  for (genvar l = 0; l < LANES; l++) begin : g_split
    assign lane_bank[l] = addr_q[l][BW-1:0];
    assign lane_row[l]  = addr_q[l][AW-1:BW];
  end

  spm_arbiter #(.LANES(LANES), .BANKS(BANKS)) u_arb (
    .pending   (pending),
    .lane_bank (lane_bank),
    .grant     (grant),
    .bank_hit  (bank_hit),
    .bank_lane (bank_lane)
  );

  // bank array, each fed by its selected lane
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic en_b;
    assign en_b = (state == ST_RUN) && bank_hit[b];
    spm_bank #(.ROWS(ROWS), .DW(DW)) u_bank (
      .clk   (clk),
      .en    (en_b),
      .we    (we_q),
      .row   (lane_row[bank_lane[b]]),
      .wdata (wd_q[bank_lane[b]]),
      .rdata (bank_dout[b])
    );
  end

  spm_return #(.LANES(LANES), .BANKS(BANKS), .DW(DW)) u_ret (
    .bank_dout (bank_dout),
    .lane_bank (lane_bank),
    .lane_dout (lane_dout)
  );

  assign left_after = pending & ~grant;

  // group controller and result capture
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pending  <= '0;
      mask_q   <= '0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wd_q     <= '0;
      gnt_q    <= '0;
      rd_q     <= '0;
      rsp_done <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      gnt_q    <= '0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            pending <= req_mask;
            mask_q  <= req_mask;
            we_q    <= req_we;
            addr_q  <= req_addr;
            wd_q    <= req_wdata;
            rd_q    <= '0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          pending <= left_after;
          gnt_q   <= grant;
          if (left_after == '0) begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          state    <= ST_IDLE;
          rsp_done <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      // bank data arrives one cycle after the grant
      for (int l = 0; l < LANES; l++) begin
        if (gnt_q[l] && !we_q) begin
          rd_q[l] <= lane_dout[l];
        end
      end
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_rdata = rd_q;

  // ---------------- assertions ----------------
  logic [LANES-1:0] lower_rival;
  always_comb begin
    lower_rival = '0;
    for (int l = 1; l < LANES; l++) begin
      for (int j = 0; j < l; j++) begin
        if (pending[j] && (addr_q[j][BW-1:0] == addr_q[l][BW-1:0])) begin
          lower_rival[l] = 1'b1;
        end
      end
    end
  end

  AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
    (grant & ~pending) == '0);                                  // R2

  AST_PROGRESS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && pending != '0) |=>
      ($countones(pending) < $past($countones(pending))));      // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (pending != '0) |-> !req_ready);                            // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);                                    // R9

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);                                    // R9

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !req_valid) |=> $stable(rsp_rdata));          // R7

  for (genvar l = 0; l < LANES; l++) begin : g_ast
    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
      grant[l] |-> !lower_rival[l]);                            // R2
    AST_NO_IDLE_BANK: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RUN && pending[l] && !lower_rival[l]) |-> grant[l]); // R2
    AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !mask_q[l] |-> (rd_q[l] == '0));                          // R6
  end

endmodule

// File: tb/bank_scratchpad_tb.sv
module bank_scratchpad_tb;

  localparam int LANES = 32;
  localparam int BANKS = 32;
  localparam int ROWS  = 64;
  localparam int DW    = 32;
  localparam int AW    = 11;
  localparam int WORDS = BANKS * ROWS;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                req_valid = 1'b0;
  logic                req_we = 1'b0;
  logic [LANES-1:0]    req_mask = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES*DW-1:0] req_wdata = '0;
  logic                req_ready;
  logic [LANES*DW-1:0] rsp_rdata;
  logic                rsp_done;

  always #2 clk = ~clk;   // 250 MHz

  bank_scratchpad u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_mask(req_mask), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5678;

  // ---------------- reference model ----------------
  logic [DW-1:0] mmem [WORDS];
  logic [DW-1:0] exp_rd [LANES];
  int m_busy = 0;
  bit m_done = 0;
  int m_lat  = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0;
      m_done = 0;
      for (int l = 0; l < LANES; l++) exp_rd[l] = '0;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (req_valid) begin
          int cnt [BANKS];
          int mx;
          mx = 0;
          for (int b = 0; b < BANKS; b++) cnt[b] = 0;
          for (int l = 0; l < LANES; l++) begin
            if (req_mask[l]) begin
              int a;
              a = int'(req_addr[l*AW +: AW]);
              cnt[a % BANKS]++;
              if (cnt[a % BANKS] > mx) mx = cnt[a % BANKS];
            end
          end
          if (mx < 1) mx = 1;
          m_busy = mx + 1;
          m_lat  = mx + 2;
          for (int l = 0; l < LANES; l++) begin
            int a;
            a = int'(req_addr[l*AW +: AW]);
            if (req_we) begin
              exp_rd[l] = '0;
              if (req_mask[l]) mmem[a] = req_wdata[l*DW +: DW];
            end else begin
              exp_rd[l] = req_mask[l] ? mmem[a] : '0;
            end
          end
        end
      end else begin
        m_busy--;
        if (m_busy == 0) m_done = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(req_ready == (m_busy == 0), "R8", "req_ready", longint'(req_ready), longint'(m_busy == 0));
      chk(rsp_done == m_done, "R9", "rsp_done", longint'(rsp_done), longint'(m_done));
      if (m_busy == 0) begin
        bit ok;
        int bad_l;
        ok = 1;
        bad_l = 0;
        for (int l = LANES - 1; l >= 0; l--) begin
          if (rsp_rdata[l*DW +: DW] !== exp_rd[l]) begin
            ok = 0;
            bad_l = l;
          end
        end
        chk(ok, "R7", $sformatf("rdata lane %0d", bad_l),
            longint'(rsp_rdata[bad_l*DW +: DW]), longint'(exp_rd[bad_l]));
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [AW-1:0] g_addr [LANES];
  logic [DW-1:0] g_wd   [LANES];

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic run_group(input bit we, input logic [LANES-1:0] mask, output int lat);
    @(negedge clk);
    req_we   = we;
    req_mask = mask;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW]  = g_addr[l];
      req_wdata[l*DW +: DW] = g_wd[l];
    end
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic [DW-1:0] lane_out(input int l);
    return rsp_rdata[l*DW +: DW];
  endfunction

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1, "R10", "ready after reset", longint'(req_ready), 1);
    chk(rsp_done == 1'b0, "R10", "done after reset", longint'(rsp_done), 0);
    chk(rsp_rdata == '0, "R10", "rdata after reset", longint'(rsp_rdata[63:0]), 0);

    // fill the whole store, stride 1 (R1, one pass each)
    for (int g = 0; g < WORDS / LANES; g++) begin
      for (int l = 0; l < LANES; l++) begin
        g_addr[l] = AW'(g * LANES + l);
        g_wd[l]   = (g * LANES + l) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F;
      end
      run_group(1'b1, '1, lat);
      if (g == 0) chk(lat == 3, "R3", "write stride1 latency", lat, 3);
    end

    // read stride 1 back
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(200 + l);
    run_group(1'b0, '1, lat);
    chk(lane_out(7) == (207 * 32'h9E37_79B1 ^ 32'h5A5A_0F0F), "R1", "readback lane7",
        longint'(lane_out(7)), longint'(207 * 32'h9E37_79B1 ^ 32'h5A5A_0F0F));
    repeat (4) @(negedge clk);   // R7 results held while idle

    // stride 32: all lanes in one bank
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(32 * l + 5);
    run_group(1'b0, '1, lat);
    chk(lat == 34, "R4", "stride32 latency", lat, 34);

    // stride 33: one lane per bank
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(33 * l);
    run_group(1'b0, '1, lat);
    chk(lat == 3, "R5", "stride33 latency", lat, 3);

    // stride 32 addresses but only one lane active in that bank
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(32 * l + 9);
    run_group(1'b0, 32'h0000_0100, lat);
    chk(lat == 3, "R6", "masked conflict latency", lat, 3);
    chk(lane_out(0) == '0, "R6", "inactive lane zero", longint'(lane_out(0)), 0);

    // empty mask
    run_group(1'b0, '0, lat);
    chk(lat == 3, "R6", "empty group latency", lat, 3);

    // duplicate write addresses: highest lane wins
    for (int l = 0; l < LANES; l++) begin
      g_addr[l] = AW'(100);
      g_wd[l]   = 32'h1111 * (l + 1);
    end
    run_group(1'b1, 32'h0000_000F, lat);
    chk(lat == 6, "R2", "dup write latency", lat, 6);
    chk(rsp_rdata == '0, "R7", "write group rdata", longint'(rsp_rdata[63:0]), 0);
    run_group(1'b0, 32'h0000_0001, lat);
    chk(lane_out(0) == 32'h4444, "R2", "dup write winner", longint'(lane_out(0)), 32'h4444);

    // request offered while busy is ignored (R8)
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(32 * l + 3);
    @(negedge clk);
    req_we = 1'b0;
    req_mask = '1;
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = g_addr[l];
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_we = 1'b1;
    for (int l = 0; l < LANES; l++) req_wdata[l*DW +: DW] = 32'hDEAD_0000 + l;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    lat = 11;
    while (!rsp_done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 34, "R8", "busy group latency", lat, 34);
    run_group(1'b0, '1, lat);
    chk(lane_out(4) == ((32 * 4 + 3) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F), "R8", "ignored write",
        longint'(lane_out(4)), longint'((32 * 4 + 3) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F));

    // random mixed groups (R3, R1, R6)
    for (int it = 0; it < 40; it++) begin
      logic [LANES-1:0] m;
      bit w;
      w = (it % 3 == 0);
      m = (it % 4 == 0) ? '1 : LANES'(rnd());
      for (int l = 0; l < LANES; l++) begin
        if (it % 2 == 0) g_addr[l] = AW'(((rnd() >> 8) % 4) * 32 + ((rnd() >> 12) % 6));
        else             g_addr[l] = AW'(rnd() >> 5);
        g_wd[l] = rnd();
      end
      run_group(w, m, lat);
      chk(lat == m_lat, "R3", "random latency", lat, m_lat);
      repeat (it % 3) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    summary();
  end

endmodule